// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-to-physical page mappings for a system with 14-bit virtual addresses, 12-bit physical addresses and 64-byte pages. Its sixteen entries are organised as four sets of four ways. A lookup uses two bits of the virtual page number to choose a set and compares the remaining six bits against the tags of all four ways at once. On a hit it returns the physical address in the same cycle, with the page offset passed through untouched.

A lookup that misses opens a walk request to an external page-table walker, which answers with a fill carrying a physical page number, a present flag and a global flag. A present fill is written into the set, into the lowest invalid way or, when the set is full, into the way named by a per-set round-robin pointer. A fill marked not present writes nothing and produces a one-cycle page-fault pulse. Entries can be dropped one at a time, all at once, or selectively on a task switch, when entries flagged global survive.

Top module: `tlb_top`

## Requirements
- R1: Virtual address bits 5:0 are the page offset and appear unchanged as physical address bits 5:0; bits 7:6 pick the set, bits 13:8 are the tag, and on a hit the physical address is {stored page number, offset}.
- R2: `lk_hit` is high in the same cycle as `lk_valid` exactly when a valid entry of the selected set holds the requested tag; a different tag in the same set gives no hit.
- R3: After reset no entry is valid, `walk_req` is low and `fault` is low.
- R4: A lookup that misses while no walk is open raises `walk_req` from the next cycle, with `walk_vpn` equal to virtual address bits 13:6, and both hold until a fill arrives.
- R5: A fill with `fill_present` high during an open walk writes the entry; from the next cycle `walk_req` is low and a lookup of that page hits with the filled page number.
- R6: A fill with `fill_present` low writes no entry, closes the walk, and drives `fault` high for exactly the next cycle.
- R7: A present fill goes into the lowest-numbered invalid way of its set.
- R8: When all four ways of the set are valid, the fill replaces the way selected by that set's 2-bit pointer; each pointer starts at 0 after reset and increments by one on every present fill of its set, including fills into invalid ways.
- R9: `inv_one` clears only the entry whose tag matches `inv_vpn` bits 7:2 in the set given by `inv_vpn` bits 1:0; other entries keep hitting.
- R10: `inv_all` clears every entry; from the next cycle no lookup hits.
- R11: `flush_local` clears every entry whose global flag is 0 and keeps every entry whose global flag is 1.
- R12: While a walk is open, further misses do not change `walk_vpn`; a `fill_valid` with no walk open writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found, same cycle |
| lk_paddr | output | 12 | Translated physical address |
| walk_req | output | 1 | Walk request to the page-table walker |
| walk_vpn | output | 8 | Virtual page number being walked |
| fill_valid | input | 1 | Walker answer strobe |
| fill_present | input | 1 | Walker found a present page |
| fill_global | input | 1 | Global flag of the filled entry |
| fill_ppn | input | 6 | Physical page number of the filled entry |
| fault | output | 1 | One-cycle page-fault pulse |
| inv_one | input | 1 | Drop one entry |
| inv_vpn | input | 8 | Page number of the entry to drop |
| inv_all | input | 1 | Drop all entries |
| flush_local | input | 1 | Drop all non-global entries |

## Verification
Hit and physical address are due combinationally, so the bench drives a lookup after a falling edge and samples one nanosecond later, then withdraws the request before the rising edge so no walk is opened by accident. The walk request, the written entry, the fault pulse and every invalidation take effect at the first rising edge after the stimulus, so those results are sampled at the following falling edge. Replacement order is checked through a scripted sequence of fills and drops in one set whose survivors are then probed one lookup at a time.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 14;
    localparam int PA_W  = 12;
    localparam int OFF_W = 6;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    typedef entry_t [WAYS-1:0] set_t;

    typedef struct packed {
        set_t [SETS-1:0]              tbl;
        logic [SETS-1:0][WAY_W-1:0]   rr;
        logic                         pend;
        logic [VPN_W-1:0]             pend_vpn;
        logic                         fault;
    } state_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            oh,
    output logic                       any
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign oh[w] = vld[w] && (tags[w] == key);
    end
    assign any = |oh;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr,
    output logic [WAY_W-1:0] way
);
    logic found;
    always_comb begin
        way   = rr;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[w] && !found) begin
                way   = WAY_W'(w);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic             fill_present,
    input  logic             fill_global,
    input  logic [PPN_W-1:0] fill_ppn,
    output logic             fault,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_all,
    input  logic             flush_local
);
    state_t q, d;

    logic [IDX_W-1:0] lk_idx, inv_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, inv_tag, fl_tag;

    assign lk_idx  = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag  = lk_vaddr[VA_W-1 -: TAG_W];
    assign inv_idx = inv_vpn[IDX_W-1:0];
    assign inv_tag = inv_vpn[VPN_W-1 -: TAG_W];
    assign fl_idx  = q.pend_vpn[IDX_W-1:0];
    assign fl_tag  = q.pend_vpn[VPN_W-1 -: TAG_W];

    logic [WAYS-1:0]            lk_vld, inv_vld, fl_vld;
    logic [WAYS-1:0][TAG_W-1:0] lk_tags, inv_tags;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_vld[w]   = q.tbl[lk_idx][w].valid;
            lk_tags[w]  = q.tbl[lk_idx][w].tag;
            inv_vld[w]  = q.tbl[inv_idx][w].valid;
            inv_tags[w] = q.tbl[inv_idx][w].tag;
            fl_vld[w]   = q.tbl[fl_idx][w].valid;
        end
    end

    logic [WAYS-1:0]  lk_oh, inv_oh;
    logic             lk_any, inv_any;
    logic [WAY_W-1:0] vic_way;

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld(lk_vld), .tags(lk_tags), .key(lk_tag), .oh(lk_oh), .any(lk_any)
    );

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_inv_match (
        .vld(inv_vld), .tags(inv_tags), .key(inv_tag), .oh(inv_oh), .any(inv_any)
    );

    tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .vld(fl_vld), .rr(q.rr[fl_idx]), .way(vic_way)
    );

    logic [PPN_W-1:0] sel_ppn;
    always_comb begin
        sel_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_oh[w]) sel_ppn = sel_ppn | q.tbl[lk_idx][w].ppn;
        end
    end

    always_comb begin
        d       = q;
        d.fault = 1'b0;

        if (lk_valid && !lk_any && !q.pend) begin
            d.pend     = 1'b1;
            d.pend_vpn = lk_vaddr[VA_W-1:OFF_W];
        end

        if (q.pend && fill_valid) begin
            d.pend = 1'b0;
            if (fill_present) begin
                d.tbl[fl_idx][vic_way].valid = 1'b1;
                d.tbl[fl_idx][vic_way].glob  = fill_global;
                d.tbl[fl_idx][vic_way].tag   = fl_tag;
                d.tbl[fl_idx][vic_way].ppn   = fill_ppn;
                d.rr[fl_idx] = WAY_W'(q.rr[fl_idx] + 1'b1);
            end else begin
                d.fault = 1'b1;
            end
        end

        if (inv_one && inv_any) begin
            for (int w = 0; w < WAYS; w++) begin
                if (inv_oh[w]) d.tbl[inv_idx][w].valid = 1'b0;
            end
        end

        if (flush_local) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (!d.tbl[s][w].glob) d.tbl[s][w].valid = 1'b0;
                end
            end
        end

        if (inv_all) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    d.tbl[s][w].valid = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lk_hit   = lk_valid && lk_any;
    assign lk_paddr = {sel_ppn, lk_vaddr[OFF_W-1:0]};
    assign walk_req = q.pend;
    assign walk_vpn = q.pend_vpn;
    assign fault    = q.fault;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             walk_req,
    input logic [VPN_W-1:0] walk_vpn,
    input logic             fill_valid,
    input logic             fill_present,
    input logic             fault,
    input logic             inv_all
);
    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_valid);

    p_walk_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> $past(lk_valid && !lk_hit));

    p_walk_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn)));

    p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(walk_req && fill_valid && !fill_present));

    p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    p_invall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !lk_hit);
endmodule

bind tlb_top tlb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_present(fill_present), .fault(fault),
    .inv_all(inv_all)
);

// File: tb/test_tlb_top.sv
module test_tlb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [13:0] lk_vaddr;
    logic        lk_hit;
    logic [11:0] lk_paddr;
    logic        walk_req;
    logic [7:0]  walk_vpn;
    logic        fill_valid, fill_present, fill_global;
    logic [5:0]  fill_ppn;
    logic        fault;
    logic        inv_one;
    logic [7:0]  inv_vpn;
    logic        inv_all, flush_local;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tlb_top i_tlb_top (.*);

    function automatic logic [13:0] mk(input logic [5:0] tag, input logic [1:0] idx,
                                       input logic [5:0] off);
        return {tag, idx, off};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [13:0] va, input bit eh, input logic [11:0] ep,
                        input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #1;
        chk(lk_hit == eh, req, "hit", 32'(lk_hit), 32'(eh));
        if (eh) chk(lk_paddr == ep, req, "paddr", 32'(lk_paddr), 32'(ep));
        #1 lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [13:0] va, input logic [5:0] ppn,
                          input bit present, input bit glob, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(walk_req == 1'b1, "R4", "walk_req open", 32'(walk_req), 1);
        chk(walk_vpn == va[13:6], "R4", "walk_vpn", 32'(walk_vpn), 32'(va[13:6]));
        fill_valid   = 1'b1;
        fill_ppn     = ppn;
        fill_present = present;
        fill_global  = glob;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(walk_req == 1'b0, req, "walk closed", 32'(walk_req), 0);
        chk(fault == !present, req, "fault", 32'(fault), 32'(!present));
    endtask

    task automatic pulse_inv_one(input logic [7:0] vpn);
        @(negedge clk);
        inv_one = 1'b1;
        inv_vpn = vpn;
        @(negedge clk);
        inv_one = 1'b0;
    endtask

    task automatic t_reset();
        chk(walk_req == 1'b0, "R3", "walk_req", 32'(walk_req), 0);
        chk(fault == 1'b0, "R3", "fault", 32'(fault), 0);
        look(14'h03D4, 1'b0, 12'h0, "R3");
    endtask

    task automatic t_basic();
        refill(14'h03D4, 6'h0D, 1'b1, 1'b0, "R5");
        look(14'h03D4, 1'b1, 12'h354, "R5");
        look(14'h03C0, 1'b1, 12'h340, "R1");
        look(14'h03FF, 1'b1, 12'h37F, "R1");
        look(14'h07D4, 1'b0, 12'h0, "R2");
        look(14'h0394, 1'b0, 12'h0, "R2");
    endtask

    task automatic t_replace();
        for (int t = 1; t <= 4; t++)
            refill(mk(6'(t), 2'd1, 6'h0), 6'(t + 32), 1'b1, 1'b0, "R7");
        for (int t = 1; t <= 4; t++)
            look(mk(6'(t), 2'd1, 6'h5), 1'b1, {6'(t + 32), 6'h5}, "R7");
        refill(mk(6'd5, 2'd1, 6'h0), 6'd37, 1'b1, 1'b0, "R8");
        look(mk(6'd1, 2'd1, 6'h0), 1'b0, 12'h0, "R8");
        for (int t = 2; t <= 5; t++)
            look(mk(6'(t), 2'd1, 6'h0), 1'b1, {6'(t + 32), 6'h0}, "R8");
        pulse_inv_one({6'd9, 2'd1});
        for (int t = 2; t <= 5; t++)
            look(mk(6'(t), 2'd1, 6'h0), 1'b1, {6'(t + 32), 6'h0}, "R9");
        pulse_inv_one({6'd3, 2'd1});
        look(mk(6'd3, 2'd1, 6'h0), 1'b0, 12'h0, "R9");
        look(mk(6'd2, 2'd1, 6'h0), 1'b1, {6'd34, 6'h0}, "R9");
        look(mk(6'd4, 2'd1, 6'h0), 1'b1, {6'd36, 6'h0}, "R9");
        refill(mk(6'd6, 2'd1, 6'h0), 6'd38, 1'b1, 1'b0, "R7");
        for (int t = 4; t <= 6; t++)
            look(mk(6'(t), 2'd1, 6'h0), 1'b1, {6'(t + 32), 6'h0}, "R7");
        look(mk(6'd2, 2'd1, 6'h0), 1'b1, {6'd34, 6'h0}, "R7");
        refill(mk(6'd7, 2'd1, 6'h0), 6'd39, 1'b1, 1'b0, "R8");
        look(mk(6'd6, 2'd1, 6'h0), 1'b0, 12'h0, "R8");
        look(mk(6'd2, 2'd1, 6'h0), 1'b1, {6'd34, 6'h0}, "R8");
        look(mk(6'd4, 2'd1, 6'h0), 1'b1, {6'd36, 6'h0}, "R8");
        look(mk(6'd5, 2'd1, 6'h0), 1'b1, {6'd37, 6'h0}, "R8");
        look(mk(6'd7, 2'd1, 6'h0), 1'b1, {6'd39, 6'h0}, "R8");
    endtask

    task automatic t_fault();
        refill(mk(6'h2E, 2'd2, 6'h0F), 6'h11, 1'b0, 1'b0, "R6");
        @(negedge clk);
        chk(fault == 1'b0, "R6", "fault after pulse", 32'(fault), 0);
        look(mk(6'h2E, 2'd2, 6'h0F), 1'b0, 12'h0, "R6");
    endtask

    task automatic t_pending();
        @(negedge clk);
        fill_valid = 1'b1; fill_present = 1'b1; fill_global = 1'b0; fill_ppn = 6'h22;
        @(negedge clk);
        fill_valid = 1'b0;
        look(mk(6'h10, 2'd2, 6'h0), 1'b0, 12'h0, "R12");
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = mk(6'h11, 2'd3, 6'h0);
        @(negedge clk);
        lk_vaddr = mk(6'h12, 2'd0, 6'h0);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(walk_vpn == {6'h11, 2'd3}, "R12", "walk_vpn held", 32'(walk_vpn), 32'({6'h11, 2'd3}));
        fill_valid = 1'b1; fill_present = 1'b1; fill_ppn = 6'h2A;
        @(negedge clk);
        fill_valid = 1'b0;
        look(mk(6'h11, 2'd3, 6'h3), 1'b1, {6'h2A, 6'h3}, "R12");
        look(mk(6'h12, 2'd0, 6'h0), 1'b0, 12'h0, "R12");
    endtask

    task automatic t_flush();
        refill(mk(6'h20, 2'd0, 6'h0), 6'h01, 1'b1, 1'b1, "R11");
        refill(mk(6'h21, 2'd2, 6'h0), 6'h02, 1'b1, 1'b0, "R11");
        @(negedge clk); flush_local = 1'b1;
        @(negedge clk); flush_local = 1'b0;
        look(mk(6'h20, 2'd0, 6'h7), 1'b1, {6'h01, 6'h7}, "R11");
        look(mk(6'h21, 2'd2, 6'h0), 1'b0, 12'h0, "R11");
        look(mk(6'h11, 2'd3, 6'h0), 1'b0, 12'h0, "R11");
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        look(mk(6'h20, 2'd0, 6'h7), 1'b0, 12'h0, "R10");
        look(mk(6'd7, 2'd1, 6'h0), 1'b0, 12'h0, "R10");
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        fill_valid = 1'b0; fill_present = 1'b0; fill_global = 1'b0; fill_ppn = '0;
        inv_one = 1'b0; inv_vpn = '0; inv_all = 1'b0; flush_local = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_replace();
        t_fault();
        t_pending();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule